// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Reset Synchronizers

This block is a first-in first-out buffer whose producer and consumer run on unrelated clocks. Words are written on the write clock and read on the read clock. The two sides meet only through Gray-coded pointers that are retimed by two-flop synchronizers. The write side reports full, almost full and a sticky overflow-error flag. The read side reports empty and presents each word on a registered data output.

One active-low asynchronous reset input serves both domains. Each domain has its own reset conditioner. A compile-time mode bit either passes the raw reset straight through, or sends it through a register chain. The chain asserts reset at once and releases it on a clock edge of that domain. Its length is chosen per domain by a 2-bit code. The conditioned reset clears that domain's pointer and flags.

The almost-full threshold is a 7-bit parameter. While almost_full is low, at least threshold+1 words are guaranteed free, so the producer may issue that many writes without looking at full.

Top module: `xclk_fifo`

## Requirements
- R1: Driving arst_n low clears both domains at once, with no clock edge needed: empty=1, full=0, almost_full=0, write_err=0.
- R2: With BYPASS_SYNC=0, each domain's reset conditioner has code+2 stages: code 00 gives 2, 01 gives 3, 10 gives 4 and 11 gives 5. The default code is 00. If arst_n rises between clock edges, the first write accepted is at write-clock edge code+3 after the release.
- R3: With BYPASS_SYNC=1, both domains follow arst_n directly and the depth codes have no effect. The first write-clock edge after release already accepts a write.
- R4: Words leave in the order they were written. rd_data takes the oldest word on the read-clock edge where rd_en=1 and empty=0.
- R5: full is 1 exactly when 2^ADDR_W words are held, as seen in the write domain.
- R6: A write while full is dropped and does not move the write pointer. It sets write_err, which stays 1 until write-side reset.
- R7: almost_full is 1 when the free count is at most AFULL_OFS. While it is 0, AFULL_OFS+1 back-to-back writes are all stored and do not set write_err.
- R8: empty is 1 when no word is held, as seen in the read domain. A read while empty is ignored: the read pointer and rd_data keep their values.
- R9: A pointer crossing domains changes in at most one bit per clock edge of its own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| arst_n | input | 1 | Active-low asynchronous reset shared by both domains |
| wr_clk | input | 1 | Write-domain clock |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No free location (write domain) |
| almost_full | output | 1 | Free count at most AFULL_OFS |
| write_err | output | 1 | Sticky: a write was attempted while full |
| rd_clk | input | 1 | Read-domain clock |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered oldest word |
| empty | output | 1 | No stored word (read domain) |

## Verification
The bench releases reset between edges on three copies of the block: the default 2-stage chain, a 5-stage chain and bypass mode. It counts which words got in. A chain tapped at the wrong stage, or a bypass that still waits, shows up as missing or extra leading words. A table walks the occupancy up through the almost-full threshold into full and overflow, then back down to empty and reads past empty. A design with an off-by-one threshold would raise almost_full one word late. A design that stored overflow writes, or let write_err clear, would corrupt the read-back order or the flag. A design that moved the read pointer on an empty read would return a stale or repeated word. A final reset taken with data held must empty the buffer and clear the error without any clock.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;

   typedef enum logic [1:0] {
      SYNC_2STG = 2'b00,
      SYNC_3STG = 2'b01,
      SYNC_4STG = 2'b10,
      SYNC_5STG = 2'b11
   } sync_code_e;

   localparam int unsigned SYNC_MIN_STAGES = 2;
   localparam int unsigned PTR_SYNC_STAGES = 2;

   function automatic int unsigned stages_for(input sync_code_e code);
      return SYNC_MIN_STAGES + 32'(code);
   endfunction

endpackage

// File: rtl/xclk_rst_sync.sv
module xclk_rst_sync
   import xclk_fifo_pkg::*;
#(
   parameter sync_code_e CODE   = SYNC_2STG,
   parameter bit         BYPASS = 1'b0
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_n_o
);

   localparam int unsigned N = stages_for(CODE);

   generate
      if (N < 2 || N > 5) begin : g_bad_depth
         $error("xclk_rst_sync: stage count out of range");
      end
   endgenerate

   logic [N-1:0] chain_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain_q <= '0;
      else         chain_q <= {chain_q[N-2:0], 1'b1};
   end

   generate
      if (BYPASS) begin : g_raw
         assign rst_n_o = arst_n;
      end else begin : g_tap
         assign rst_n_o = chain_q[N-1];
      end
   endgenerate

   AST_RST_ASSERT_ASYNC: assert property (@(posedge clk)
      !arst_n |-> !rst_n_o);                                  // R1
   AST_RST_RELEASE_GATED: assert property (@(posedge clk)
      $rose(rst_n_o) |-> arst_n);                             // R2

endmodule

// File: rtl/xclk_gray_sync.sv
module xclk_gray_sync #(
   parameter int unsigned W      = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("xclk_gray_sync: at least two stages required");
      end
   endgenerate

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/xclk_wr_ctl.sv
module xclk_wr_ctl #(
   parameter int unsigned ADDR_W    = 4,
   parameter logic [6:0]  AFULL_OFS = 7'd4,
   localparam int unsigned PTR_W    = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  rgray_s,
   output logic [ADDR_W-1:0] waddr,
   output logic [PTR_W-1:0]  wgray,
   output logic              wr_fire,
   output logic              full,
   output logic              almost_full,
   output logic              write_err
);

   localparam int unsigned       DEPTH   = 1 << ADDR_W;
   localparam logic [PTR_W-1:0]  DEPTH_P = PTR_W'(DEPTH);
   localparam logic [PTR_W-1:0]  AF_LIM  = PTR_W'(AFULL_OFS);

   generate
      if (32'(AFULL_OFS) >= DEPTH) begin : g_bad_ofs
         $error("xclk_wr_ctl: almost-full offset must be below depth");
      end
   endgenerate

   function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
      logic [PTR_W-1:0] b;
      b[PTR_W-1] = g[PTR_W-1];
      for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [PTR_W-1:0] wbin_q, wgray_q, wbin_nxt, rbin_s, used, free_cnt;
   logic             err_q;

   assign rbin_s      = g2b(rgray_s);
   assign used        = wbin_q - rbin_s;
   assign free_cnt    = DEPTH_P - used;
   assign full        = (wgray_q == {~rgray_s[PTR_W-1 -: 2], rgray_s[PTR_W-3:0]});
   assign almost_full = (free_cnt <= AF_LIM);
   assign wr_fire     = wr_en & ~full;
   assign wbin_nxt    = wbin_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin_q  <= '0;
         wgray_q <= '0;
         err_q   <= 1'b0;
      end else begin
         if (wr_fire) begin
            wbin_q  <= wbin_nxt;
            wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
         end
         if (wr_en && full) err_q <= 1'b1;
      end
   end

   assign waddr     = wbin_q[ADDR_W-1:0];
   assign wgray     = wgray_q;
   assign write_err = err_q;

   AST_WGRAY_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(wgray_q ^ $past(wgray_q)) <= 1);             // R9
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full) |=> $stable(wbin_q));                    // R6
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      write_err |=> write_err);                                // R6
   AST_FULL_IN_MARGIN: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> almost_full);                                   // R7

endmodule

// File: rtl/xclk_rd_ctl.sv
module xclk_rd_ctl #(
   parameter int unsigned ADDR_W = 4,
   localparam int unsigned PTR_W = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [PTR_W-1:0]  wgray_s,
   output logic [ADDR_W-1:0] raddr,
   output logic [PTR_W-1:0]  rgray,
   output logic              rd_fire,
   output logic              empty
);

   logic [PTR_W-1:0] rbin_q, rgray_q, rbin_nxt;

   assign empty    = (rgray_q == wgray_s);
   assign rd_fire  = rd_en & ~empty;
   assign rbin_nxt = rbin_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin_q  <= '0;
         rgray_q <= '0;
      end else if (rd_fire) begin
         rbin_q  <= rbin_nxt;
         rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
      end
   end

   assign raddr = rbin_q[ADDR_W-1:0];
   assign rgray = rgray_q;

   AST_RGRAY_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rgray_q ^ $past(rgray_q)) <= 1);             // R9
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && empty) |=> $stable(rgray_q));                  // R8

endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
   import xclk_fifo_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 4,
   parameter logic [6:0]  AFULL_OFS   = 7'd4,
   parameter sync_code_e  WR_SYNC     = SYNC_2STG,
   parameter sync_code_e  RD_SYNC     = SYNC_2STG,
   parameter bit          BYPASS_SYNC = 1'b0
) (
   input  logic              arst_n,
   input  logic              wr_clk,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              full,
   output logic              almost_full,
   output logic              write_err,
   input  logic              rd_clk,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty
);

   localparam int unsigned PTR_W = ADDR_W + 1;
   localparam int unsigned DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 2 || ADDR_W > 10) begin : g_bad_addr
         $error("xclk_fifo: ADDR_W must lie in 2..10");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("xclk_fifo: DATA_W must be positive");
      end
   endgenerate

   logic              wrst_n, rrst_n, wr_fire, rd_fire;
   logic [ADDR_W-1:0] waddr, raddr;
   logic [PTR_W-1:0]  wgray, rgray, wgray_s, rgray_s;
   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] rdata_q;

   xclk_rst_sync #(.CODE(WR_SYNC), .BYPASS(BYPASS_SYNC)) u_wrst (
      .clk(wr_clk), .arst_n(arst_n), .rst_n_o(wrst_n));
   xclk_rst_sync #(.CODE(RD_SYNC), .BYPASS(BYPASS_SYNC)) u_rrst (
      .clk(rd_clk), .arst_n(arst_n), .rst_n_o(rrst_n));

   xclk_gray_sync #(.W(PTR_W), .STAGES(PTR_SYNC_STAGES)) u_r2w (
      .clk(wr_clk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
   xclk_gray_sync #(.W(PTR_W), .STAGES(PTR_SYNC_STAGES)) u_w2r (
      .clk(rd_clk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));

   xclk_wr_ctl #(.ADDR_W(ADDR_W), .AFULL_OFS(AFULL_OFS)) u_wctl (
      .clk(wr_clk), .rst_n(wrst_n), .wr_en(wr_en), .rgray_s(rgray_s),
      .waddr(waddr), .wgray(wgray), .wr_fire(wr_fire), .full(full),
      .almost_full(almost_full), .write_err(write_err));

   xclk_rd_ctl #(.ADDR_W(ADDR_W)) u_rctl (
      .clk(rd_clk), .rst_n(rrst_n), .rd_en(rd_en), .wgray_s(wgray_s),
      .raddr(raddr), .rgray(rgray), .rd_fire(rd_fire), .empty(empty));

   always_ff @(posedge wr_clk) begin
      if (wr_fire) mem[waddr] <= wr_data;
   end

   always_ff @(posedge rd_clk or negedge rrst_n) begin
      if (!rrst_n)      rdata_q <= '0;
      else if (rd_fire) rdata_q <= mem[raddr];
   end

   assign rd_data = rdata_q;

   AST_RDATA_HOLD: assert property (@(posedge rd_clk) disable iff (!rrst_n)
      (rd_en && empty) |=> $stable(rd_data));                  // R8
   AST_RESET_FLAGS: assert property (@(posedge wr_clk)
      !arst_n |-> (!full && !write_err && !almost_full));      // R1

endmodule

// File: tb/xclk_fifo_bench.sv
`timescale 1ns/1ps
module xclk_fifo_bench;
   import xclk_fifo_pkg::*;

   logic arst_n = 1'b0, wr_clk = 1'b0, rd_clk = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic full, almost_full, write_err, empty;
   logic [7:0] rd_data;
   logic d_full, d_af, d_err, d_empty, b_full, b_af, b_err, b_empty;
   logic [7:0] d_data, b_data;

   always #2   wr_clk = ~wr_clk;
   always #3.5 rd_clk = ~rd_clk;

   xclk_fifo u_xclk_fifo (
      .arst_n(arst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
      .full(full), .almost_full(almost_full), .write_err(write_err),
      .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(rd_data), .empty(empty));

   xclk_fifo #(.WR_SYNC(SYNC_5STG), .RD_SYNC(SYNC_5STG)) u_deep (
      .arst_n(arst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
      .full(d_full), .almost_full(d_af), .write_err(d_err),
      .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(d_data), .empty(d_empty));

   xclk_fifo #(.WR_SYNC(SYNC_5STG), .RD_SYNC(SYNC_4STG), .BYPASS_SYNC(1'b1)) u_raw (
      .arst_n(arst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
      .full(b_full), .almost_full(b_af), .write_err(b_err),
      .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(b_data), .empty(b_empty));

   // {writes[13:9], reads[8:4], full, almost_full, empty, write_err}
   localparam logic [13:0] VEC [9] = '{
      {5'd3, 5'd0,  4'b0000},
      {5'd8, 5'd0,  4'b0000},
      {5'd1, 5'd0,  4'b0100},   // R7 threshold: 12 held, 4 free
      {5'd4, 5'd0,  4'b1100},   // R7 blind writes, no error
      {5'd2, 5'd0,  4'b1101},   // R6 overflow
      {5'd0, 5'd5,  4'b0001},
      {5'd0, 5'd11, 4'b0011},
      {5'd0, 5'd2,  4'b0011},   // R8 reads past empty
      {5'd5, 5'd5,  4'b0011}
   };

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   logic [7:0] mq [16];
   int m_occ = 0, m_head = 0;
   logic [7:0] m_last = '0;
   logic [7:0] next_val = 8'h40;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (10) @(posedge rd_clk);
      repeat (10) @(posedge wr_clk);
      #1;
   endtask

   task automatic push();
      wr_data = next_val; wr_en = 1'b1;
      @(posedge wr_clk); #1;
      wr_en = 1'b0;
      if (m_occ < 16) begin
         mq[(m_head + m_occ) % 16] = next_val;
         m_occ++;
      end
      next_val++;
   endtask

   task automatic pop();
      rd_en = 1'b1;
      @(posedge rd_clk); #1;
      rd_en = 1'b0;
      if (m_occ > 0) begin
         m_last = mq[m_head];
         m_head = (m_head + 1) % 16;
         m_occ--;
         chk("R4 read order", int'(rd_data), int'(m_last));
      end else begin
         chk("R8 empty read keeps data", int'(rd_data), int'(m_last));
      end
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int mv[16], dv[16], bv[16];
      int mc, dc, bc;
      logic me, de, be;
      #10;
      chk("R1 reset empty", int'(empty), 1);
      chk("R1 reset full", int'(full), 0);
      chk("R1 reset almost_full", int'(almost_full), 0);
      chk("R1 reset write_err", int'(write_err), 0);

      // Release between edges while writing words 1..8 on edges 1..8.
      @(negedge wr_clk);
      arst_n = 1'b1;
      for (int k = 1; k <= 8; k++) begin
         wr_data = 8'(k); wr_en = 1'b1;
         @(posedge wr_clk); #1;
      end
      wr_en = 1'b0;
      settle();
      mc = 0; dc = 0; bc = 0;
      for (int k = 0; k < 10; k++) begin
         me = empty; de = d_empty; be = b_empty;
         rd_en = 1'b1;
         @(posedge rd_clk); #1;
         rd_en = 1'b0;
         if (!me) begin mv[mc] = int'(rd_data); mc++; end
         if (!de) begin dv[dc] = int'(d_data); dc++; end
         if (!be) begin bv[bc] = int'(b_data); bc++; end
      end
      chk("R2 two-stage accepted count", mc, 6);
      for (int k = 0; k < 6 && k < mc; k++) chk("R2 two-stage first word", mv[k], k + 3);
      chk("R2 five-stage accepted count", dc, 3);
      for (int k = 0; k < 3 && k < dc; k++) chk("R2 five-stage word", dv[k], k + 6);
      chk("R3 bypass accepted count", bc, 8);
      for (int k = 0; k < 8 && k < bc; k++) chk("R3 bypass word", bv[k], k + 1);
      m_last = rd_data;

      foreach (VEC[i]) begin
         for (int w = 0; w < int'(VEC[i][13:9]); w++) push();
         settle();
         for (int r = 0; r < int'(VEC[i][8:4]); r++) pop();
         settle();
         chk("R5 full", int'(full), int'(VEC[i][3]));
         chk("R7 almost_full", int'(almost_full), int'(VEC[i][2]));
         chk("R8 empty", int'(empty), int'(VEC[i][1]));
         chk("R6 write_err", int'(write_err), int'(VEC[i][0]));
      end

      // Reset taken with words held and the error set.
      for (int w = 0; w < 3; w++) push();
      settle();
      #1 arst_n = 1'b0;
      #1;
      chk("R1 async empty", int'(empty), 1);
      chk("R1 async full", int'(full), 0);
      chk("R1 async almost_full", int'(almost_full), 0);
      chk("R1 async write_err", int'(write_err), 0);
      m_occ = 0; m_head = 0; m_last = '0;
      @(negedge wr_clk);
      arst_n = 1'b1;
      settle();
      push();
      settle();
      pop();
      chk("R8 drained after reset", int'(empty), 1);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule